// File: doc/BRIEF.md
# Terminated Rate-1/2 Convolutional Encoder

This block turns a stream of single data bits into a stream of two-bit branch words. It implements a constraint-length-3 convolutional code with the first output bit tapped by generator 111 and the second by generator 101. Data bits arrive on a valid/ready handshake, and a flag on the final bit of a message closes that message. The encoder then inserts zero flush bits by itself until its memory is back at the all-zero state. Each message therefore starts from, and ends in, the zero state.

Each accepted bit, data or flush, produces one registered branch word one cycle later. A last-word flag marks the final flush word so downstream framing can find the message boundary. While flush bits are being inserted, the input side is held off. The current two-bit memory contents are exposed as a debug state.

Top module: `tailed_conv_encoder`

## Requirements
- R1: A synchronous active-high reset, including one asserted during a flush, clears the memory to state 0 and drops `out_valid` and `out_last`. In the first cycle after reset, `in_ready` is 1.
- R2: When `in_valid` and `in_ready` are both high at a clock edge, the bit is accepted and `out_valid` is high in the following cycle.
- R3: `out_word[1]` is the first output bit and carries input XOR both memory bits. `out_word[0]` is the second output bit and carries input XOR the oldest memory bit.
- R4: `state_dbg[1]` holds the newest memory bit and `state_dbg[0]` the oldest. After each step the new state is {input bit, previous `state_dbg[1]`}. The states are S0=00, S1=01, S2=10 and S3=11.
- R5: After a data bit accepted with `in_last` high, exactly two flush steps with input 0 follow on the next two cycles. Each one emits a valid branch word, and `in_ready` is 0 throughout both.
- R6: `out_last` is high only with the second flush word. At that point `state_dbg` is 0, and `out_last` is never high with a data word.
- R7: The message 1,0,1 produces the word sequence 11, 10, 00, 10, 11.
- R8: A single message bit 1 produces the impulse response 11, 10, 11.
- R9: `in_valid`, `in_bit` and `in_last` have no effect during the flush. The flush words and the final zero state are unchanged when they are driven high.
- R10: `in_ready` is 1 in the cycle right after the final flush word. A new message may start there, with no idle cycle, from state 0.
- R11: A cycle without an accepted bit outside the flush leaves `out_valid` low and the state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input bit offered |
| in_ready | output | 1 | Encoder can take a data bit |
| in_bit | input | 1 | Data bit |
| in_last | input | 1 | Offered bit ends the message |
| out_valid | output | 1 | Branch word valid |
| out_word | output | 2 | Branch word, bit 1 sent first |
| out_last | output | 1 | Final flush word of a message |
| state_dbg | output | K-1 | Current memory contents, newest bit high |

## Verification
The bench checks the worked examples exactly. A swapped tap or a reversed state shift shows up as a wrong second or third word in the 1,0,1 and impulse sequences. It drives all inputs high during the flush, so a design that lets the handshake leak into the flush would emit ones in the flush words or end in a nonzero state. It starts a second message on the cycle after `out_last` and pauses the input mid-message. A design with an extra idle cycle, a memory that is not flushed, or a state that drifts while idle would miscompare there. A reset issued in the middle of a flush exposes a flush counter that survives reset.

// File: rtl/cenc_pkg.sv
package cenc_pkg;

   typedef enum logic {
      PH_DATA = 1'b0,
      PH_TAIL = 1'b1
   } cenc_phase_e;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/cenc_tail_ctrl.sv
module cenc_tail_ctrl
   import cenc_pkg::*;
#(
   parameter int unsigned TAIL_LEN = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic accept,
   input  logic accept_last,
   output logic tail_active,
   output logic tail_final,
   output logic data_ready
);
   localparam int unsigned CNT_W = cnt_width(TAIL_LEN);
   localparam logic [CNT_W-1:0] CNT_END = CNT_W'(TAIL_LEN - 1);

   cenc_phase_e      phase_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_DATA;
         cnt_q   <= '0;
      end else begin
         case (phase_q)
            PH_DATA: begin
               if (accept && accept_last) begin
                  phase_q <= PH_TAIL;
                  cnt_q   <= '0;
               end
            end
            PH_TAIL: begin
               if (cnt_q == CNT_END) begin
                  phase_q <= PH_DATA;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            default: phase_q <= PH_DATA;
         endcase
      end
   end

   assign tail_active = (phase_q == PH_TAIL);
   assign tail_final  = (phase_q == PH_TAIL) && (cnt_q == CNT_END);
   assign data_ready  = (phase_q == PH_DATA);

endmodule

// File: rtl/cenc_branch_calc.sv
module cenc_branch_calc #(
   parameter int unsigned       K     = 3,
   parameter int unsigned       N_OUT = 2,
   parameter logic [N_OUT*K-1:0] GENS = '1
) (
   input  logic [K-2:0]     mem,
   input  logic             din,
   output logic [N_OUT-1:0] word
);
   logic [K-1:0] taps_in;
   assign taps_in = {din, mem};

   for (genvar i = 0; i < N_OUT; i++) begin : g_out
      localparam logic [K-1:0] G = GENS[i*K +: K];
      assign word[N_OUT-1-i] = ^(G & taps_in);
   end

endmodule

// File: rtl/tailed_conv_encoder.sv
module tailed_conv_encoder
   import cenc_pkg::*;
#(
   parameter int unsigned K        = 3,
   parameter logic [K-1:0] G_FIRST  = 3'b111,
   parameter logic [K-1:0] G_SECOND = 3'b101
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic         in_bit,
   input  logic         in_last,
   output logic         out_valid,
   output logic [1:0]   out_word,
   output logic         out_last,
   output logic [K-2:0] state_dbg
);
   localparam int unsigned MEM_W    = K - 1;
   localparam int unsigned N_OUT    = 2;
   localparam int unsigned TAIL_LEN = MEM_W;
   localparam logic [N_OUT*K-1:0] GENS = {G_SECOND, G_FIRST};

   if (K < 2) begin : g_bad_k
      $error("constraint length must be at least 2");
   end
   if (G_FIRST[K-1] != 1'b1 || G_SECOND[K-1] != 1'b1) begin : g_bad_in_tap
      $error("each generator must tap the input stage");
   end
   if (G_FIRST[0] != 1'b1 || G_SECOND[0] != 1'b1) begin : g_bad_old_tap
      $error("each generator must tap the oldest stage");
   end

   logic             data_ready, tail_active, tail_final;
   logic             accept, step, step_bit;
   logic [MEM_W-1:0] mem_q, mem_d;
   logic [N_OUT-1:0] word_d;

   assign accept   = in_valid && data_ready;
   assign step     = accept || tail_active;
   assign step_bit = tail_active ? 1'b0 : in_bit;

   cenc_tail_ctrl #(.TAIL_LEN(TAIL_LEN)) u_tail (
      .clk         (clk),
      .rst         (rst),
      .accept      (accept),
      .accept_last (in_last),
      .tail_active (tail_active),
      .tail_final  (tail_final),
      .data_ready  (data_ready)
   );

   cenc_branch_calc #(.K(K), .N_OUT(N_OUT), .GENS(GENS)) u_branch (
      .mem  (mem_q),
      .din  (step_bit),
      .word (word_d)
   );

   if (MEM_W == 1) begin : g_mem1
      assign mem_d = step_bit;
   end else begin : g_memn
      assign mem_d = {step_bit, mem_q[MEM_W-1:1]};
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         mem_q     <= '0;
         out_valid <= 1'b0;
         out_last  <= 1'b0;
         out_word  <= '0;
      end else begin
         out_valid <= step;
         out_last  <= tail_final;
         if (step) begin
            mem_q    <= mem_d;
            out_word <= word_d;
         end
      end
   end

   assign in_ready  = data_ready;
   assign state_dbg = mem_q;

endmodule

// File: rtl/cenc_checker.sv
module cenc_checker #(
   parameter int unsigned MEM_W = 2
) (
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic             in_ready,
   input logic             in_bit,
   input logic             in_last,
   input logic             out_valid,
   input logic [1:0]       out_word,
   input logic             out_last,
   input logic [MEM_W-1:0] state_dbg
);
   logic acc;
   assign acc = in_valid && in_ready;

   p_reset_clear_r1: assert property (@(posedge clk)
      $past(rst) && !rst |-> !out_valid && !out_last && state_dbg == '0 && in_ready);

   p_accept_valid_r2: assert property (@(posedge clk) disable iff (rst)
      acc |=> out_valid);

   p_first_bit_r3: assert property (@(posedge clk) disable iff (rst)
      acc |=> out_word[1] == ($past(in_bit) ^ (^$past(state_dbg))));

   p_second_bit_r3: assert property (@(posedge clk) disable iff (rst)
      acc |=> out_word[0] == ($past(in_bit) ^ $past(state_dbg[0])));

   p_state_shift_r4: assert property (@(posedge clk) disable iff (rst)
      acc |=> state_dbg[MEM_W-1] == $past(in_bit));

   p_tail_hold_r5: assert property (@(posedge clk) disable iff (rst)
      acc && in_last |=> !in_ready);

   p_last_zero_r6: assert property (@(posedge clk) disable iff (rst)
      out_last |-> out_valid && state_dbg == '0);

   p_ready_after_r10: assert property (@(posedge clk) disable iff (rst)
      out_last |-> in_ready);

   p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
      in_ready && !in_valid && !$past(rst) |=> !out_valid && $stable(state_dbg));

endmodule

bind tailed_conv_encoder cenc_checker u_chk (.*);

// File: tb/tailed_conv_encoder_tb.sv
module tailed_conv_encoder_tb;
   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic       rst, in_valid, in_ready, in_bit, in_last;
   logic       out_valid, out_last;
   logic [1:0] out_word, state_dbg;

   tailed_conv_encoder u_dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
      .in_bit(in_bit), .in_last(in_last), .out_valid(out_valid),
      .out_word(out_word), .out_last(out_last), .state_dbg(state_dbg)
   );

   int          n_chk = 0;
   int          n_bad = 0;
   bit          done  = 0;
   logic [1:0]  m_state;
   logic [63:0] wacc;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic logic [1:0] mword(input logic b, input logic [1:0] s);
      return {b ^ s[1] ^ s[0], b ^ s[0]};
   endfunction

   task automatic push(input logic b, input logic last);
      logic [1:0] exp;
      @(negedge clk);
      chk(in_ready == 1'b1, "R10 ready for data", int'(in_ready), 1);
      in_valid = 1'b1; in_bit = b; in_last = last;
      @(posedge clk); #1;
      exp     = mword(b, m_state);
      m_state = {b, m_state[1]};
      chk(out_valid == 1'b1, "R2 valid after accept", int'(out_valid), 1);
      chk(out_word == exp, "R3 data word", int'(out_word), int'(exp));
      chk(state_dbg == m_state, "R4 state", int'(state_dbg), int'(m_state));
      chk(out_last == 1'b0, "R6 no last on data", int'(out_last), 0);
      wacc = {wacc[61:0], out_word};
   endtask

   task automatic tail(input bit noise);
      logic [1:0] exp;
      for (int j = 0; j < 2; j++) begin
         @(negedge clk);
         chk(in_ready == 1'b0, "R5 ready low in flush", int'(in_ready), 0);
         in_valid = noise; in_bit = noise; in_last = noise;
         @(posedge clk); #1;
         exp     = mword(1'b0, m_state);
         m_state = {1'b0, m_state[1]};
         chk(out_valid == 1'b1, "R5 flush valid", int'(out_valid), 1);
         chk(out_word == exp, noise ? "R9 flush word" : "R5 flush word",
             int'(out_word), int'(exp));
         chk(out_last == (j == 1), "R6 last flag", int'(out_last), int'(j == 1));
         wacc = {wacc[61:0], out_word};
      end
      chk(state_dbg == 2'b00, noise ? "R9 end state" : "R6 end state", int'(state_dbg), 0);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0; in_bit = 1'b1; in_last = 1'b1;
         @(posedge clk); #1;
         chk(out_valid == 1'b0, "R11 no output when idle", int'(out_valid), 0);
         chk(state_dbg == m_state, "R11 state held", int'(state_dbg), int'(m_state));
      end
   endtask

   task automatic t_reset();
      rst = 1'b1; in_valid = 1'b0; in_bit = 1'b0; in_last = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 1'b0;
      #1;
      m_state = 2'b00;
      chk(out_valid == 1'b0, "R1 valid low", int'(out_valid), 0);
      chk(out_last == 1'b0, "R1 last low", int'(out_last), 0);
      chk(state_dbg == 2'b00, "R1 state zero", int'(state_dbg), 0);
      chk(in_ready == 1'b1, "R1 ready high", int'(in_ready), 1);
   endtask

   task automatic t_msg101();
      wacc = '0;
      push(1'b1, 1'b0); push(1'b0, 1'b0); push(1'b1, 1'b1); tail(1'b0);
      chk(wacc[9:0] == 10'b11_10_00_10_11, "R7 sequence 101",
          int'(wacc[9:0]), int'(10'b11_10_00_10_11));
      idle(1);
   endtask

   task automatic t_impulse();
      wacc = '0;
      push(1'b1, 1'b1); tail(1'b0);
      chk(wacc[5:0] == 6'b11_10_11, "R8 impulse", int'(wacc[5:0]), int'(6'b11_10_11));
      idle(1);
   endtask

   task automatic t_back_to_back();
      push(1'b0, 1'b0); push(1'b1, 1'b0); push(1'b1, 1'b0); push(1'b0, 1'b1);
      tail(1'b0);
      wacc = '0;
      push(1'b1, 1'b1); tail(1'b0);
      chk(wacc[5:0] == 6'b11_10_11, "R10 restart from zero",
          int'(wacc[5:0]), int'(6'b11_10_11));
      idle(1);
   endtask

   task automatic t_flush_noise();
      push(1'b1, 1'b0); push(1'b1, 1'b1); tail(1'b1);
      idle(1);
   endtask

   task automatic t_gaps();
      push(1'b1, 1'b0); idle(3); push(1'b1, 1'b0); idle(2);
      push(1'b0, 1'b1); tail(1'b0);
      idle(1);
   endtask

   task automatic t_long();
      logic [15:0] pat = 16'b1101_0011_1000_1011;
      for (int i = 15; i >= 0; i--) push(pat[i], i == 0);
      tail(1'b0);
      idle(1);
   endtask

   task automatic t_reset_mid_flush();
      push(1'b1, 1'b1);
      @(negedge clk); in_valid = 1'b0;
      @(posedge clk); #1;
      @(negedge clk); rst = 1'b1;
      @(posedge clk); #1;
      @(negedge clk); rst = 1'b0;
      #1;
      m_state = 2'b00;
      chk(out_valid == 1'b0, "R1 mid-flush reset valid", int'(out_valid), 0);
      chk(state_dbg == 2'b00, "R1 mid-flush reset state", int'(state_dbg), 0);
      chk(in_ready == 1'b1, "R1 mid-flush reset ready", int'(in_ready), 1);
      wacc = '0;
      push(1'b1, 1'b0); push(1'b0, 1'b0); push(1'b1, 1'b1); tail(1'b0);
      chk(wacc[9:0] == 10'b11_10_00_10_11, "R1 clean after reset",
          int'(wacc[9:0]), int'(10'b11_10_00_10_11));
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_msg101();
      t_impulse();
      t_back_to_back();
      t_flush_noise();
      t_gaps();
      t_long();
      t_reset_mid_flush();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule